// File: doc/BRIEF.md
# Parallel Bit Grouping Unit

This block sorts the bits of a data word into two groups, as chosen by a control word of the same width. Data bits whose control bit is 0 are packed to the left end of the result, and data bits whose control bit is 1 are packed to the right end. Within each group the bits keep the order they had in the input. In this block the left end of a word is bit position 0, so the first element of a word is bit 0 of the vector.

The datapath has two compaction trees of the same shape, and each tree is built from merge levels. At a leaf, a bit is either kept or replaced by a padded zero. The leaf also reports its padded-zero count as a one-hot code. At each merge level, two neighbouring sets are joined. The right set's bits are shifted left into the left set's trailing padded zeros, using the left set's one-hot count to set the shift. The two one-hot counts are also added to give the count of the joined set.

The second tree packs the control-1 bits. It takes the data in reversed order and the control word reversed and inverted, and its output is reversed back. The two partial results are then combined with OR. An optional output register adds one cycle of latency.

Top module: `bit_grouper`

## Requirements
- R1: For every data and control word, the control-0 data bits appear at positions 0, 1, 2 and so on of `group_o`, in their input order. Position 0 is the lowest vector index.
- R2: For every data and control word, the control-1 data bits fill the positions of `group_o` from the first position after the control-0 group up to position W-1, in their input order.
- R3: Take an 8-bit word with elements a..h at positions 0..7 and control bits 1,0,0,1,1,0,1,0 at the same positions. The result is b,c,f,h,a,d,e,g at positions 0..7.
- R4: When the control word is all zeros, `group_o` equals the data word.
- R5: When the control word is all ones, `group_o` equals the data word.
- R6: The number of 1 bits in `group_o` equals the number of 1 bits in the data word.
- R7: With `REG_OUT`=0 the output follows the inputs in the same cycle. With `REG_OUT`=1 the output shows the result for the inputs sampled at the previous rising clock edge. In that case, while `rst_n` is low the output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset for the output register |
| data_i | input | W | Data word; bit 0 is the left end |
| ctrl_i | input | W | Group select per bit: 0 goes left, 1 goes right |
| group_o | output | W | Regrouped word |

## Verification
The assertions assume that `data_i` and `ctrl_i` are stable across each rising edge. Each assertion compares the output with the inputs of the same cycle, or with the inputs of the previous cycle when the register is present. The bench changes its inputs only on falling edges, so the inputs hold steady around every rising edge.

The assertions are held off during reset, because the registered output is forced to zero then. In the registered case they also wait one cycle after reset ends, so that no sampled input comes from the reset window.

// File: rtl/bit_grouper.sv
module bit_grouper #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] ctrl_i,
  output logic [W-1:0] group_o
);
  localparam int LG = $clog2(W);

  logic [W-1:0] side_q [2];
  logic [W-1:0] merged;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [W-1:0] src_d, src_c;

    for (genvar i = 0; i < W; i++) begin : g_src
      if (s == 0) begin : g_fwd
        assign src_d[i] = data_i[i];
        assign src_c[i] = ctrl_i[i];
      end else begin : g_rev
        assign src_d[i] = data_i[W-1-i];
        assign src_c[i] = ~ctrl_i[W-1-i];
      end
    end

    for (genvar l = 0; l <= LG; l++) begin : g_lvl
      localparam int SZ  = 1 << l;
      localparam int KW  = SZ + 1;
      localparam int NST = W >> l;
      logic [W-1:0]       dq;
      logic [NST*KW-1:0]  kq;

      if (l == 0) begin : g_leaf
        for (genvar i = 0; i < W; i++) begin : g_bit
          assign dq[i]         = src_c[i] ? 1'b0 : src_d[i];
          assign kq[2*i +: 2]  = src_c[i] ? 2'b10 : 2'b01;
        end
      end else begin : g_merge
        localparam int M  = SZ / 2;
        localparam int HK = M + 1;
        for (genvar j = 0; j < NST; j++) begin : g_set
          logic [M-1:0]  lft, rgt;
          logic [HK-1:0] ka, kb;
          logic [SZ-1:0] o;
          logic [KW-1:0] ko;

          assign lft = g_lvl[l-1].dq[j*SZ +: M];
          assign rgt = g_lvl[l-1].dq[j*SZ+M +: M];
          assign ka  = g_lvl[l-1].kq[(2*j)*HK +: HK];
          assign kb  = g_lvl[l-1].kq[(2*j+1)*HK +: HK];

          always_comb begin
            o = {{M{1'b0}}, lft};
            for (int a = 0; a <= M; a++)
              for (int q = 0; q < M; q++)
                if (ka[a]) o[M-a+q] = o[M-a+q] | rgt[q];
          end

          always_comb begin
            ko = '0;
            for (int a = 0; a <= M; a++)
              for (int b = 0; b <= M; b++)
                if (ka[a] && kb[b]) ko[a+b] = 1'b1;
          end

          assign dq[j*SZ +: SZ] = o;
          assign kq[j*KW +: KW] = ko;
        end
      end
    end

    assign side_q[s] = g_lvl[LG].dq;
  end

  always_comb begin
    for (int i = 0; i < W; i++)
      merged[i] = side_q[0][i] | side_q[1][W-1-i];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) group_o <= '0;
      else        group_o <= merged;
  end else begin : g_comb
    assign group_o = merged;
  end
endmodule

// File: rtl/bit_grouper_chk.sv
module bit_grouper_chk #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] data_i,
  input logic [W-1:0] ctrl_i,
  input logic [W-1:0] group_o
);
  logic [W-1:0] pd, pc, sd, sc, lmask;
  logic         pv, live;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd <= '0; pc <= '0; pv <= 1'b0;
    end else begin
      pd <= data_i; pc <= ctrl_i; pv <= 1'b1;
    end

  assign sd   = REG_OUT ? pd : data_i;
  assign sc   = REG_OUT ? pc : ctrl_i;
  assign live = REG_OUT ? pv : 1'b1;

  always_comb begin
    int k;
    k = $countones(~sc);
    for (int i = 0; i < W; i++) lmask[i] = (i < k);
  end

  AST_LEFT_GROUP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $countones(group_o & lmask) == $countones(sd & ~sc)); // R1
  AST_RIGHT_GROUP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $countones(group_o & ~lmask) == $countones(sd & sc)); // R2
  AST_ZERO_CTRL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sc == '0) |-> group_o == sd); // R4
  AST_ONES_CTRL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sc == '1) |-> group_o == sd); // R5
  AST_WEIGHT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $countones(group_o) == $countones(sd)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    (REG_OUT && !rst_n) |=> (!rst_n) |-> group_o == '0); // R7
endmodule

bind bit_grouper bit_grouper_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_i(data_i), .ctrl_i(ctrl_i), .group_o(group_o));

// File: tb/test_bit_grouper.sv
module test_bit_grouper;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  d8 = '0, c8 = '0, o8;
  logic [15:0] d16 = '0, c16 = '0, o16;
  logic [63:0] d64 = '0, c64 = '0, o64;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_grouper #(.W(8),  .REG_OUT(1'b0)) i_bit_grouper_w8 (
    .clk(clk), .rst_n(rst_n), .data_i(d8), .ctrl_i(c8), .group_o(o8));
  bit_grouper #(.W(16), .REG_OUT(1'b0)) i_bit_grouper_w16 (
    .clk(clk), .rst_n(rst_n), .data_i(d16), .ctrl_i(c16), .group_o(o16));
  bit_grouper #(.W(64), .REG_OUT(1'b1)) i_bit_grouper (
    .clk(clk), .rst_n(rst_n), .data_i(d64), .ctrl_i(c64), .group_o(o64));

  function automatic logic [63:0] ref_group(logic [63:0] d, logic [63:0] c, int w);
    logic [63:0] r = '0;
    int p = 0;
    for (int i = 0; i < w; i++) if (!c[i]) begin r[p] = d[i]; p++; end
    for (int i = 0; i < w; i++) if (c[i])  begin r[p] = d[i]; p++; end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      if (n_bad < 20) $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run64(logic [63:0] d, logic [63:0] c, string req);
    @(negedge clk); d64 = d; c64 = c;
    @(posedge clk); #1;
    check(req, o64, ref_group(d, c, 64));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R7 reset", o64, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 worked example
    @(negedge clk); d8 = 8'b1100_1011; c8 = 8'b0101_1001; #1;
    check("R3", {56'd0, o8}, 64'h00000000_000000B9);

    // R1/R2 exhaustive at width 8
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk); d8 = v[7:0]; c8 = v[15:8]; #1;
      check("R1/R2 w8", {56'd0, o8}, ref_group({56'd0, d8}, {56'd0, c8}, 8));
    end

    // R1/R2 and R6 random at width 16
    for (int v = 0; v < 3000; v++) begin
      @(negedge clk); d16 = 16'($urandom); c16 = 16'($urandom); #1;
      check("R1/R2 w16", {48'd0, o16}, ref_group({48'd0, d16}, {48'd0, c16}, 16));
      check("R6 w16", 64'($countones(o16)), 64'($countones(d16)));
    end
    @(negedge clk); d16 = 16'hA5C3; c16 = '0; #1;
    check("R4 w16", {48'd0, o16}, {48'd0, d16});
    @(negedge clk); c16 = '1; #1;
    check("R5 w16", {48'd0, o16}, {48'd0, d16});

    // width 64 with output register (R7 latency)
    run64(64'h0123_4567_89AB_CDEF, 64'd0, "R4 w64");
    run64(64'hFEDC_BA98_7654_3210, '1, "R5 w64");
    run64('1, 64'h5555_5555_5555_5555, "R1/R2 alt");
    run64(64'h0F0F_F0F0_3C3C_C3C3, 64'hFFFF_FFFF_0000_0000, "R1/R2 halves");
    run64(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, "R2 single");
    run64(64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, "R1 single");
    for (int v = 0; v < 2000; v++)
      run64({$urandom, $urandom}, {$urandom, $urandom}, "R1/R2 R7 w64");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule